// File: doc/BRIEF.md
# Slice Job Descriptor Walker

This block lets a CPU hand a list of slice-encoding jobs to an encoding engine without touching each job itself. The CPU builds descriptors of eight 32-bit words in shared memory, links them through a next-pointer word, writes the address of the first descriptor into the block's base register and pulses go. The block reads each descriptor over a single-outstanding memory master port and presents the job fields to the engine with a one-cycle start strobe. It waits for the engine's done and then writes a pass or error code into the descriptor's status word. Then it either follows the link or, at a null link, drops busy and raises a one-cycle interrupt.

Only one job is ever in flight. No memory traffic occurs while the engine works. An engine error is recorded in the status word and does not stop the walk.

Top module: `slice_desc_fetcher`

## Requirements
- R1: After synchronous reset, busy, irq, mem_req, mem_we and job_start are all low.
- R2: A go pulse while idle starts a walk at the base register value. For each descriptor, word offsets 0 to 6 are read in ascending order at byte addresses base+4*k. Each read is a single request whose address and write-enable hold steady until mem_ack.
- R3: When word 6 has been read, job_start pulses high for exactly one cycle. At that moment the job outputs show word 0 (input address), word 1 (input size), word 2 (output address), word 3 (output size), word 4 (slice/frame info) and word 5 (reference address).
- R4: From job_start until job_done is seen, mem_req stays low.
- R5: On job_done, word 7 of the same descriptor is written. It gets 0x1 (bit 0 set, success) when job_err is low and 0x2 (bit 1 set, error) when job_err is high. The walk continues after an error.
- R6: After the status write is acknowledged, a nonzero word 6 makes the next fetch start at that address. A zero word 6 ends the walk: busy falls and irq is high for exactly that one cycle.
- R7: go while busy is ignored; the running walk's memory sequence is unchanged.
- R8: The base register keeps its value after a walk, so a later go with no new base write walks the same chain again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_we | input | 1 | Loads base_in into the base register |
| base_in | input | 32 | First descriptor address |
| go | input | 1 | Start a walk when idle |
| busy | output | 1 | Walk in progress |
| irq | output | 1 | One-cycle end-of-chain pulse |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Completes the current request |
| job_start | output | 1 | One-cycle job launch strobe |
| job_in_addr | output | 32 | Raw input start address |
| job_in_size | output | 32 | Raw input size |
| job_out_addr | output | 32 | Output buffer start address |
| job_out_size | output | 32 | Output buffer size |
| job_info | output | 32 | Slice and frame information |
| job_ref_addr | output | 32 | Reference frame address |
| job_done | input | 1 | Engine finished the job |
| job_err | input | 1 | Engine job failed, sampled with job_done |

## Verification
The hardest cases to reach are the ones that depend on what happened to earlier descriptors in the same walk. One is an error status on a middle descriptor with the walk still going on to the next. Another is a go arriving in the middle of a walk. The bench places descriptors at descending addresses so that only the link words can steer the walk. It sweeps chain lengths of one to four against every pattern of per-job error results, varies the memory acknowledge latency, and injects a go during the first job of each walk. It then compares the full logged memory transaction sequence against the sequence worked out from the chain.

// File: rtl/sdf_pkg.sv
package sdf_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WAIT, ST_WRITE} sdf_state_e;
  // descriptor word positions (order is fixed by the engine contract)
  localparam int DESC_WORDS = 8;
  localparam int W_IN_ADDR  = 0;
  localparam int W_IN_SIZE  = 1;
  localparam int W_OUT_ADDR = 2;
  localparam int W_OUT_SIZE = 3;
  localparam int W_INFO     = 4;
  localparam int W_REF      = 5;
  localparam int W_LINK     = 6;
  localparam int W_STATUS   = 7;
  localparam logic [31:0] STAT_PASS = 32'h1;
  localparam logic [31:0] STAT_FAIL = 32'h2;
endpackage

// File: rtl/sdf_job_regs.sv
module sdf_job_regs #(
  parameter int W      = 32,
  parameter int NWORDS = 7,
  parameter int IW     = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_en,
  input  logic [IW-1:0]     cap_idx,
  input  logic [W-1:0]      cap_data,
  output logic [NWORDS*W-1:0] words_flat
);
  logic [W-1:0] word_q [NWORDS];

  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)
        word_q[g] <= '0;
      else if (cap_en && cap_idx == IW'(g))
        word_q[g] <= cap_data;
    end
    assign words_flat[g*W +: W] = word_q[g];
  end
endmodule

// File: rtl/sdf_walker.sv
module sdf_walker
  import sdf_pkg::*;
#(
  parameter int W  = 32,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          base_we,
  input  logic [W-1:0]  base_in,
  input  logic          go,
  input  logic [W-1:0]  link_word,
  output logic          busy,
  output logic          irq,
  output logic          mem_req,
  output logic          mem_we,
  output logic [W-1:0]  mem_addr,
  output logic [W-1:0]  mem_wdata,
  input  logic          mem_ack,
  output logic          job_start,
  input  logic          job_done,
  input  logic          job_err,
  output logic          cap_en,
  output logic [IW-1:0] cap_idx
);
  localparam logic [IW-1:0] LAST_RD = IW'(W_LINK);
  localparam logic [W-1:0]  STAT_OFS = W'(W_STATUS * 4);

  sdf_state_e    state;
  logic [W-1:0]  base_q;
  logic [W-1:0]  cur_q;
  logic [IW-1:0] idx_q;

  assign cap_en  = (state == ST_READ) && mem_ack;
  assign cap_idx = idx_q;

  always_ff @(posedge clk) begin
    if (rst) base_q <= '0;
    else if (base_we) base_q <= base_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cur_q     <= '0;
      idx_q     <= '0;
      busy      <= 1'b0;
      irq       <= 1'b0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      job_start <= 1'b0;
    end else begin
      irq       <= 1'b0;
      job_start <= 1'b0;
      case (state)
        ST_IDLE: if (go) begin
          cur_q    <= base_q;
          idx_q    <= '0;
          busy     <= 1'b1;
          mem_req  <= 1'b1;
          mem_we   <= 1'b0;
          mem_addr <= base_q;
          state    <= ST_READ;
        end
        ST_READ: if (mem_ack) begin
          if (idx_q == LAST_RD) begin
            mem_req   <= 1'b0;
            job_start <= 1'b1;
            state     <= ST_WAIT;
          end else begin
            idx_q    <= idx_q + 1'b1;
            mem_addr <= cur_q + (W'(idx_q + 1'b1) << 2);
          end
        end
        ST_WAIT: if (job_done) begin
          mem_req   <= 1'b1;
          mem_we    <= 1'b1;
          mem_addr  <= cur_q + STAT_OFS;
          mem_wdata <= job_err ? STAT_FAIL : STAT_PASS;
          state     <= ST_WRITE;
        end
        ST_WRITE: if (mem_ack) begin
          mem_we <= 1'b0;
          if (link_word == '0) begin
            mem_req <= 1'b0;
            busy    <= 1'b0;
            irq     <= 1'b1;
            state   <= ST_IDLE;
          end else begin
            cur_q    <= link_word;
            idx_q    <= '0;
            mem_addr <= link_word;
            state    <= ST_READ;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: a pending request keeps its address and direction until acknowledged
  assert_req_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  // R3: launch strobe lasts one cycle
  assert_start_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    job_start |=> !job_start);
  // R4: engine owns the slot; no bus traffic at launch
  assert_quiet_at_start_R4: assert property (@(posedge clk) disable iff (rst)
    job_start |-> !mem_req);
  // R6: walk ends only together with the interrupt
  assert_end_irq_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> irq);
  assert_irq_idle_R6: assert property (@(posedge clk) disable iff (rst)
    irq |-> (!busy && !mem_req));
  assert_irq_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);
endmodule

// File: rtl/slice_desc_fetcher.sv
module slice_desc_fetcher
  import sdf_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         base_we,
  input  logic [W-1:0] base_in,
  input  logic         go,
  output logic         busy,
  output logic         irq,
  output logic         mem_req,
  output logic         mem_we,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  input  logic [W-1:0] mem_rdata,
  input  logic         mem_ack,
  output logic         job_start,
  output logic [W-1:0] job_in_addr,
  output logic [W-1:0] job_in_size,
  output logic [W-1:0] job_out_addr,
  output logic [W-1:0] job_out_size,
  output logic [W-1:0] job_info,
  output logic [W-1:0] job_ref_addr,
  input  logic         job_done,
  input  logic         job_err
);
  localparam int IW     = $clog2(DESC_WORDS);
  localparam int NWORDS = W_LINK + 1;

  logic              cap_en;
  logic [IW-1:0]     cap_idx;
  logic [NWORDS*W-1:0] words;

  sdf_job_regs #(.W(W), .NWORDS(NWORDS), .IW(IW)) u_regs (
    .clk(clk), .rst(rst), .cap_en(cap_en), .cap_idx(cap_idx),
    .cap_data(mem_rdata), .words_flat(words)
  );

  sdf_walker #(.W(W), .IW(IW)) u_walk (
    .clk(clk), .rst(rst), .base_we(base_we), .base_in(base_in), .go(go),
    .link_word(words[W_LINK*W +: W]), .busy(busy), .irq(irq),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .job_start(job_start),
    .job_done(job_done), .job_err(job_err), .cap_en(cap_en), .cap_idx(cap_idx)
  );

  assign job_in_addr  = words[W_IN_ADDR*W  +: W];
  assign job_in_size  = words[W_IN_SIZE*W  +: W];
  assign job_out_addr = words[W_OUT_ADDR*W +: W];
  assign job_out_size = words[W_OUT_SIZE*W +: W];
  assign job_info     = words[W_INFO*W     +: W];
  assign job_ref_addr = words[W_REF*W      +: W];
endmodule

// File: tb/slice_desc_fetcher_test.sv
module slice_desc_fetcher_test;
  logic clk = 0, rst = 1;
  logic base_we = 0, go = 0;
  logic [31:0] base_in = 0;
  logic busy, irq, mem_req, mem_we, mem_ack = 0, job_start;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = 0;
  logic [31:0] j_ia, j_is, j_oa, j_os, j_inf, j_ref;
  logic job_done = 0, job_err = 0;

  int checks = 0, fails = 0, cycles = 0, dly = 0, cnt = 0;
  logic [31:0] mem [256];
  logic [31:0] lg_addr [64];
  logic        lg_we   [64];
  logic [31:0] lg_data [64];
  int lg_n = 0;

  always #10 clk = ~clk;

  slice_desc_fetcher uut (
    .clk(clk), .rst(rst), .base_we(base_we), .base_in(base_in), .go(go),
    .busy(busy), .irq(irq), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack), .job_start(job_start), .job_in_addr(j_ia),
    .job_in_size(j_is), .job_out_addr(j_oa), .job_out_size(j_os),
    .job_info(j_inf), .job_ref_addr(j_ref), .job_done(job_done), .job_err(job_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory responder with programmable latency, logs every transaction
  always @(negedge clk) begin
    if (rst) begin
      mem_ack = 0; cnt = 0;
    end else if (mem_ack) begin
      mem_ack = 0;
    end else if (mem_req) begin
      if (cnt >= dly) begin
        cnt = 0;
        mem_ack = 1;
        if (lg_n < 64) begin
          lg_addr[lg_n] = mem_addr; lg_we[lg_n] = mem_we; lg_data[lg_n] = mem_wdata;
        end
        lg_n++;
        if (mem_we) mem[mem_addr[9:2]] = mem_wdata;
        else mem_rdata = mem[mem_addr[9:2]];
      end else cnt++;
    end
  end

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      summary();
    end
  end

  function automatic logic [31:0] dbase(int j);
    return 32'h300 - 32'(j) * 32'h40;   // descending placement
  endfunction

  function automatic logic [31:0] fld(int j, int k);
    return 32'hC0DE_0000 | (32'(j) << 8) | 32'(k);
  endfunction

  task automatic run_chain(input int len, input int mask, input bit load_base);
    int t;
    for (int a = 0; a < 256; a++) mem[a] = 32'hDEAD_0000 | 32'(a);
    for (int j = 0; j < len; j++) begin
      for (int k = 0; k < 6; k++) mem[(dbase(j) >> 2) + k] = fld(j, k);
      mem[(dbase(j) >> 2) + 6] = (j < len - 1) ? dbase(j + 1) : 32'h0;
      mem[(dbase(j) >> 2) + 7] = 32'h0;
    end
    lg_n = 0;
    if (load_base) begin
      base_in = dbase(0); base_we = 1; @(negedge clk); base_we = 0;
    end
    go = 1; @(negedge clk); go = 0;
    for (int j = 0; j < len; j++) begin
      t = 0;
      while (!job_start && t < 2000) begin @(negedge clk); t++; end
      chk("R3 start seen", {31'b0, job_start}, 32'h1);
      chk("R3 in_addr", j_ia, fld(j, 0));
      chk("R3 in_size", j_is, fld(j, 1));
      chk("R3 out_addr", j_oa, fld(j, 2));
      chk("R3 out_size", j_os, fld(j, 3));
      chk("R3 info", j_inf, fld(j, 4));
      chk("R3 ref_addr", j_ref, fld(j, 5));
      @(negedge clk);
      chk("R3 start one cycle", {31'b0, job_start}, 32'h0);
      if (j == 0) go = 1;              // R7: go while busy
      @(negedge clk);
      go = 0;
      chk("R4 no req while engine runs", {31'b0, mem_req}, 32'h0);
      @(negedge clk);
      chk("R4 no req while engine runs", {31'b0, mem_req}, 32'h0);
      job_done = 1; job_err = mask[j]; @(negedge clk);
      job_done = 0; job_err = 0;
    end
    t = 0;
    while (busy && t < 2000) begin @(negedge clk); t++; end
    chk("R6 irq at busy fall", {31'b0, irq}, 32'h1);
    @(negedge clk);
    chk("R6 irq one cycle", {31'b0, irq}, 32'h0);
    chk("R7 transaction count", 32'(lg_n), 32'(len * 8));
    for (int j = 0; j < len && j < 8; j++) begin
      for (int k = 0; k < 7; k++)
        chk("R2 read order", {lg_we[j*8+k], lg_addr[j*8+k]}, {1'b0, dbase(j) + 32'(4*k)});
      chk("R5 status write addr", {lg_we[j*8+7], lg_addr[j*8+7]}, {1'b1, dbase(j) + 32'd28});
      chk("R5 status value", mem[(dbase(j) >> 2) + 7], mask[j] ? 32'h2 : 32'h1);
    end
    chk("R6 idle after chain", {30'b0, busy, mem_req}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 reset outputs", {27'b0, busy, irq, mem_req, mem_we, job_start}, 32'h0);
    for (int len = 1; len <= 4; len++)
      for (int m = 0; m < (1 << len); m++) begin
        dly = (len + m) % 3;
        run_chain(len, m, 1'b1);
      end
    dly = 1;
    run_chain(3, 5, 1'b0);   // R8: no new base write, same chain walked
    summary();
  end
endmodule